// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

Two processor cores exchange 32-bit words through a pair of one-way queues, one for each direction. Both cores use the same register map: a write-data register, a read strobe that returns the oldest word, and a status register. The identity each core presents picks the queue it uses. A core with identity k pushes into queue k, and the core with the other identity pops from queue k. So a message written by identity 0 is read by identity 1, and a message written by identity 1 is read by identity 0.

The status word shows whether the incoming queue holds data and whether the outgoing queue has room. It also holds two sticky error bits. One records a pop from an empty queue and the other records a push into a full queue. Writing the status register clears both error bits for that core. Each port also has an interrupt line, which stays high while incoming data waits or while an error bit is set.

The status word uses these bit positions: bit 0 is data-valid, bit 1 is room-available, bit 2 is the read-while-empty error and bit 3 is the write-while-full error. The two ports are normally given different identities. If they present the same identity, port A is served and port B's accesses do nothing.

Top module: `mailbox_pair`

## Requirements
- R1: Each queue holds up to 8 words of 32 bits, and words come out in the order they went in.
- R2: A port with identity k writes into queue k and reads from queue 1-k. This holds for either assignment of identities to the two ports.
- R3: A read strobe loads the read-data output at the next clock edge. The output then keeps that value until the next read strobe on the same port.
- R4: Status bit 0 (data-valid) is 1 exactly when the port's incoming queue holds at least one word.
- R5: Status bit 1 (room-available) is 1 exactly when the port's outgoing queue holds fewer than 8 words.
- R6: A write into a full outgoing queue is discarded and sets status bit 3 (write-while-full). That bit stays set until it is cleared.
- R7: A read from an empty incoming queue returns zero, leaves the queue unchanged and sets status bit 2 (read-while-empty). That bit stays set until it is cleared.
- R8: A status-register write clears bits 2 and 3 for that identity. If an error happens in the same cycle as the clear, the error wins and its bit stays set.
- R9: A port's interrupt output is high exactly while status bit 0, bit 2 or bit 3 is set for that port.
- R10: When both ports present the same identity, port B's write, read and status-write strobes have no effect.
- R11: After synchronous reset both queues are empty, all error bits are clear and both read-data outputs are zero.
- R12: A write into a full queue is discarded even when the other core pops from that queue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_id | input | 1 | Core identity presented by port A |
| pa_wr_en | input | 1 | Port A push strobe |
| pa_wr_data | input | 32 | Port A word to push |
| pa_rd_en | input | 1 | Port A pop strobe |
| pa_rd_data | output | 32 | Port A popped word (registered) |
| pa_st_wr | input | 1 | Port A status write (clears error bits) |
| pa_status | output | 4 | Port A status {wof, roe, rdy, vld} |
| pa_irq | output | 1 | Port A interrupt |
| pb_id | input | 1 | Core identity presented by port B |
| pb_wr_en | input | 1 | Port B push strobe |
| pb_wr_data | input | 32 | Port B word to push |
| pb_rd_en | input | 1 | Port B pop strobe |
| pb_rd_data | output | 32 | Port B popped word (registered) |
| pb_st_wr | input | 1 | Port B status write (clears error bits) |
| pb_status | output | 4 | Port B status {wof, roe, rdy, vld} |
| pb_irq | output | 1 | Port B interrupt |

## Verification
The hardest case to reach is a full queue that receives a push and a pop in the same cycle. The queue must first be filled to exactly eight words, and then both cores must act on the same clock edge. The bench does this in a single step, strobing port A's write and port B's read together. It then drains the queue and shows that the extra word never appears before the queue reports empty. The bench also tests the case where an error and its clear arrive in the same cycle. Separately, it swaps and merges the port identities to show how steering behaves and that port B is ignored when both ports share an identity.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NCORE  = 2;
  localparam int ST_W   = 4;
  localparam int ST_VLD = 0;
  localparam int ST_RDY = 1;
  localparam int ST_ROE = 2;
  localparam int ST_WOF = 3;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W = 32,
  parameter int D = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;
  localparam int CW = $clog2(D + 1);

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(D));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(D - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(D - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(D));
  p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop |=> full && $stable(wptr));
  p_full_pop_drop_r12: assert property (@(posedge clk) disable iff (rst)
    push && full && pop |=> !full && $stable(wptr));
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
    pop && empty |=> $stable(rptr));
endmodule

// File: rtl/mbox_err.sv
module mbox_err #(
  parameter int NC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] set_roe,
  input  logic [NC-1:0] set_wof,
  input  logic [NC-1:0] clr,
  output logic [NC-1:0] roe,
  output logic [NC-1:0] wof
);
  for (genvar k = 0; k < NC; k++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst) begin
        roe[k] <= 1'b0;
        wof[k] <= 1'b0;
      end else begin
        roe[k] <= set_roe[k] | (roe[k] & ~clr[k]);
        wof[k] <= set_wof[k] | (wof[k] & ~clr[k]);
      end
    end

    p_roe_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      set_roe[k] |=> roe[k]);
    p_wof_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      set_wof[k] |=> wof[k]);
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
      clr[k] && !set_roe[k] && !set_wof[k] |=> !roe[k] && !wof[k]);
  end
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair
  import mbox_pkg::*;
#(
  parameter int W = 32,
  parameter int D = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pa_id,
  input  logic            pa_wr_en,
  input  logic [W-1:0]    pa_wr_data,
  input  logic            pa_rd_en,
  output logic [W-1:0]    pa_rd_data,
  input  logic            pa_st_wr,
  output logic [ST_W-1:0] pa_status,
  output logic            pa_irq,
  input  logic            pb_id,
  input  logic            pb_wr_en,
  input  logic [W-1:0]    pb_wr_data,
  input  logic            pb_rd_en,
  output logic [W-1:0]    pb_rd_data,
  input  logic            pb_st_wr,
  output logic [ST_W-1:0] pb_status,
  output logic            pb_irq
);
  logic             same_id, b_wr, b_rd, b_st;
  logic [NCORE-1:0] push, pop, full, empty;
  logic [NCORE-1:0] set_roe, set_wof, clr, roe, wof;
  logic [W-1:0]     din  [NCORE];
  logic [W-1:0]     head [NCORE];
  logic             a_src, b_src;

  assign same_id = (pa_id == pb_id);
  assign b_wr    = pb_wr_en & ~same_id;
  assign b_rd    = pb_rd_en & ~same_id;
  assign b_st    = pb_st_wr & ~same_id;
  assign a_src   = ~pa_id;
  assign b_src   = ~pb_id;

  for (genvar k = 0; k < NCORE; k++) begin : g_q
    localparam logic KID = 1'(k);
    localparam logic OID = 1'(NCORE - 1 - k);

    assign push[k]    = (pa_wr_en && pa_id == KID) || (b_wr && pb_id == KID);
    assign pop[k]     = (pa_rd_en && pa_id == OID) || (b_rd && pb_id == OID);
    assign din[k]     = (pa_wr_en && pa_id == KID) ? pa_wr_data : pb_wr_data;
    assign set_wof[k] = push[k] && full[k];
    assign set_roe[k] = ((pa_rd_en && pa_id == KID) || (b_rd && pb_id == KID))
                        && empty[NCORE - 1 - k];
    assign clr[k]     = (pa_st_wr && pa_id == KID) || (b_st && pb_id == KID);

    mbox_fifo #(.W(W), .D(D)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push[k]),
      .pop   (pop[k]),
      .din   (din[k]),
      .head  (head[k]),
      .full  (full[k]),
      .empty (empty[k])
    );
  end

  mbox_err #(.NC(NCORE)) u_err (
    .clk     (clk),
    .rst     (rst),
    .set_roe (set_roe),
    .set_wof (set_wof),
    .clr     (clr),
    .roe     (roe),
    .wof     (wof)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_rd_data <= '0;
      pb_rd_data <= '0;
    end else begin
      if (pa_rd_en) pa_rd_data <= empty[a_src] ? '0 : head[a_src];
      if (b_rd)     pb_rd_data <= empty[b_src] ? '0 : head[b_src];
    end
  end

  always_comb begin
    pa_status         = '0;
    pa_status[ST_VLD] = ~empty[a_src];
    pa_status[ST_RDY] = ~full[pa_id];
    pa_status[ST_ROE] = roe[pa_id];
    pa_status[ST_WOF] = wof[pa_id];
    pb_status         = '0;
    pb_status[ST_VLD] = ~empty[b_src];
    pb_status[ST_RDY] = ~full[pb_id];
    pb_status[ST_ROE] = roe[pb_id];
    pb_status[ST_WOF] = wof[pb_id];
  end

  assign pa_irq = pa_status[ST_VLD] | pa_status[ST_ROE] | pa_status[ST_WOF];
  assign pb_irq = pb_status[ST_VLD] | pb_status[ST_ROE] | pb_status[ST_WOF];

  p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    pa_rd_en && !pa_status[ST_VLD] |=> pa_rd_data == '0);
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !pa_rd_en |=> $stable(pa_rd_data));
  p_same_id_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    same_id && pb_rd_en |=> $stable(pb_rd_data));
  p_single_push_r2: assert property (@(posedge clk) disable iff (rst)
    !same_id |-> $countones({pa_wr_en, b_wr}) == $countones(push));
endmodule

// File: tb/mailbox_pair_tb.sv
module mailbox_pair_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        pa_id, pa_wr_en, pa_rd_en, pa_st_wr;
  logic        pb_id, pb_wr_en, pb_rd_en, pb_st_wr;
  logic [31:0] pa_wr_data, pb_wr_data, pa_rd_data, pb_rd_data;
  logic [3:0]  pa_status, pb_status;
  logic        pa_irq, pb_irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mailbox_pair u_dut (
    .clk(clk), .rst(rst),
    .pa_id(pa_id), .pa_wr_en(pa_wr_en), .pa_wr_data(pa_wr_data),
    .pa_rd_en(pa_rd_en), .pa_rd_data(pa_rd_data), .pa_st_wr(pa_st_wr),
    .pa_status(pa_status), .pa_irq(pa_irq),
    .pb_id(pb_id), .pb_wr_en(pb_wr_en), .pb_wr_data(pb_wr_data),
    .pb_rd_en(pb_rd_en), .pb_rd_data(pb_rd_data), .pb_st_wr(pb_st_wr),
    .pb_status(pb_status), .pb_irq(pb_irq)
  );

  // op: 0 = A writes, 1 = B writes, 2 = A reads, 3 = B reads; {op, data, expected}
  localparam logic [65:0] VEC [8] = '{
    {2'd0, 32'h1111_1111, 32'h0},
    {2'd0, 32'h2222_2222, 32'h0},
    {2'd1, 32'hAAAA_0001, 32'h0},
    {2'd3, 32'h0,         32'h1111_1111},
    {2'd2, 32'h0,         32'hAAAA_0001},
    {2'd0, 32'h3333_3333, 32'h0},
    {2'd3, 32'h0,         32'h2222_2222},
    {2'd3, 32'h0,         32'h3333_3333}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic aw, input logic ar, input logic ast,
                      input logic bw, input logic br, input logic bst,
                      input logic [31:0] ad, input logic [31:0] bd);
    pa_wr_en = aw; pa_rd_en = ar; pa_st_wr = ast; pa_wr_data = ad;
    pb_wr_en = bw; pb_rd_en = br; pb_st_wr = bst; pb_wr_data = bd;
    @(negedge clk);
    pa_wr_en = 0; pa_rd_en = 0; pa_st_wr = 0;
    pb_wr_en = 0; pb_rd_en = 0; pb_st_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; pa_id = 0; pb_id = 1;
    pa_wr_en = 0; pa_rd_en = 0; pa_st_wr = 0; pa_wr_data = 0;
    pb_wr_en = 0; pb_rd_en = 0; pb_st_wr = 0; pb_wr_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R11 reset state
    chk("R11 pa_status", 32'(pa_status), 32'h2);
    chk("R11 pb_status", 32'(pb_status), 32'h2);
    chk("R11 pa_rd_data", pa_rd_data, 32'h0);
    chk("R11 irq", {30'h0, pa_irq, pb_irq}, 32'h0);

    // R1 R2 table walk
    for (int i = 0; i < 8; i++) begin
      logic [1:0] op;
      op = VEC[i][65:64];
      case (op)
        2'd0: step(1, 0, 0, 0, 0, 0, VEC[i][63:32], 0);
        2'd1: step(0, 0, 0, 1, 0, 0, 0, VEC[i][63:32]);
        2'd2: begin step(0, 1, 0, 0, 0, 0, 0, 0); chk("R2 table A read", pa_rd_data, VEC[i][31:0]); end
        default: begin step(0, 0, 0, 0, 1, 0, 0, 0); chk("R2 table B read", pb_rd_data, VEC[i][31:0]); end
      endcase
    end

    // R5 R4 R9 fill queue 0
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, 32'hC0DE_0000 + i, 0);
    chk("R5 full no room", 32'(pa_status), 32'h0);
    chk("R4 vld at reader", 32'(pb_status), 32'h3);
    chk("R9 irq on data", 32'(pb_irq), 32'h1);
    // R6 overflow
    step(1, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, 0);
    chk("R6 wof set", 32'(pa_status), 32'h8);
    chk("R9 irq on wof", 32'(pa_irq), 32'h1);
    // R1 order and discard
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R1 order", pb_rd_data, 32'hC0DE_0000 + i);
    end
    chk("R4 vld clear", 32'(pb_status), 32'h2);
    // R3 hold
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 hold", pb_rd_data, 32'hC0DE_0007);
    // R7 underflow
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 zero data", pb_rd_data, 32'h0);
    chk("R7 roe set", 32'(pb_status), 32'h6);
    step(1, 0, 0, 0, 0, 0, 32'h5555_5555, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 pointer kept", pb_rd_data, 32'h5555_5555);
    // R8 clear and set-wins
    step(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R8 clear wof", 32'(pa_status), 32'h2);
    step(0, 0, 0, 0, 1, 1, 0, 0);
    chk("R8 set wins", 32'(pb_status), 32'h6);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 clear roe", 32'(pb_status), 32'h2);
    chk("R9 irq low", 32'(pb_irq), 32'h0);

    // R12 full push with simultaneous pop
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, 32'h0100_0000 + i, 0);
    step(1, 0, 0, 0, 1, 0, 32'h9999_9999, 0);
    chk("R12 pop data", pb_rd_data, 32'h0100_0000);
    chk("R12 wof and room", 32'(pa_status), 32'hA);
    for (int i = 1; i < 8; i++) step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R12 last word", pb_rd_data, 32'h0100_0007);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R12 extra discarded", pb_rd_data, 32'h0);
    step(0, 0, 1, 0, 0, 1, 0, 0);

    // R10 same identity: port B ignored
    pb_id = 0;
    step(0, 0, 0, 1, 0, 0, 0, 32'h7777_7777);
    pb_id = 1;
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R10 write ignored", pb_rd_data, 32'h0);
    chk("R10 no data", 32'(pa_status), 32'h2);
    step(0, 0, 0, 0, 0, 1, 0, 0);

    // R2 swapped identities
    pa_id = 1; pb_id = 0;
    step(1, 0, 0, 0, 0, 0, 32'hABCD_0123, 0);
    chk("R2 swap vld", 32'(pb_status), 32'h3);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R2 swap read", pb_rd_data, 32'hABCD_0123);
    pa_id = 0; pb_id = 1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule